// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 12-bit successive-approximation converter. Software or hardware events start a conversion. The block then steps a trial code out to an external DAC, one bit per step with the MSB first, and reads back a single comparator decision after each step. When the last bit is settled, it stores the finished word in a 16-bit result register and raises an end-of-conversion flag. That flag can drive an interrupt request. The analog path (input selection, gain stage, reference and comparator) sits outside the block.

The start event comes from one of four sources, chosen by a 2-bit mode field: a software start pulse, either of two timer overflow pulses, or a rising edge on an asynchronous convert-start pin. Steps are paced by a clock enable that fires once every (N+1) system clocks, where N is a 5-bit divider setting. The finished word can be unsigned for single-ended inputs or two's complement for differential inputs. It can be placed at the bottom of the 16-bit word (right-justified) or at the top (left-justified).

The result is a register read by software, not a data stream, so no valid/ready handshake applies. All control and status pins are plain levels or single-cycle pulses.

Top module: `sar_conv_seq`

## Requirements
- R1: `trig_mode` picks the start source: 0 = `sw_start` pulse, 1 = `tmr2_ovf` pulse, 2 = `tmr3_ovf` pulse, 3 = rising edge of `ext_start`, which passes through a two-flop synchronizer first. Pulses on the sources that are not selected start nothing.
- R2: A trigger is ignored while `enable` is 0. Dropping `enable` during a conversion aborts it: `busy` clears on the next edge, the flag is not set, and `result` keeps its previous value.
- R3: `busy` rises on the edge that accepts a trigger. It stays high for exactly 12*(`div_n`+1) clock cycles, because each step takes `div_n`+1 cycles.
- R4: One cycle after `busy` falls at the end of a completed conversion, `eoc_flag` is set. It stays set until a `flag_clr` pulse, and a completion in the same cycle as a clear wins. `irq` is high exactly when `eoc_flag` and `irq_en` are both 1.
- R5: The first trial code is 0x800. The bits are then resolved from the MSB down, and a comparator value of 1 means the input is at or above the trial code. In single-ended mode (`diff_mode`=0) the 12-bit code is the input level clamped to the range 0..4095, so full scale gives 0x0FFF and half scale gives 0x0800.
- R6: With `justify`=0 the 12-bit code sits in `result[11:0]` and bits 15:12 are the fill. With `justify`=1 it sits in `result[15:4]` and bits 3:0 are 0.
- R7: In differential mode the code is two's complement, made by inverting the MSB of the converted code. Right-justified, bits 15:12 copy the sign. Zero input gives 0x0000, positive overrange gives 0x07FF, and negative overrange gives 0xF800.
- R8: A trigger that arrives while `busy` is 1 is ignored. The conversion length and its result are unchanged.
- R9: `result` changes only when a conversion completes, and then holds until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Converter enable; clearing it aborts a conversion |
| trig_mode | input | 2 | Start-source select |
| sw_start | input | 1 | Software start pulse |
| tmr2_ovf | input | 1 | Timer 2 overflow pulse |
| tmr3_ovf | input | 1 | Timer 3 overflow pulse |
| ext_start | input | 1 | Asynchronous external convert-start pin |
| div_n | input | 5 | Step-rate divider; each step is div_n+1 cycles |
| diff_mode | input | 1 | 1 = two's-complement (differential) coding |
| justify | input | 1 | 1 = left-justified result |
| irq_en | input | 1 | Interrupt request enable |
| flag_clr | input | 1 | Pulse that clears the end-of-conversion flag |
| cmp_in | input | 1 | Comparator decision for the current trial code |
| dac_code | output | 12 | Trial code sent to the DAC |
| busy | output | 1 | High while a conversion runs |
| eoc_flag | output | 1 | End-of-conversion flag |
| irq | output | 1 | Interrupt request |
| result | output | 16 | Formatted conversion word |

## Verification
The assertions assume that `div_n`, `diff_mode` and `justify` stay steady while a conversion runs, and that `cmp_in` follows `dac_code` within the same cycle, as a settled comparator would. The bench changes configuration only while `busy` is low. Its comparator is a continuous compare of a held integer level against `dac_code`. Trigger pulses last one full clock and are driven on the falling edge, so they meet the synchronizer's timing and the gating assertions can take clean single-cycle events for granted.

// File: rtl/sar_conv_pkg.sv
`timescale 1ns/1ps
package sar_conv_pkg;
  typedef enum logic [1:0] {
    SRC_SOFT  = 2'd0,
    SRC_TMR2  = 2'd1,
    SRC_TMR3  = 2'd2,
    SRC_PIN   = 2'd3
  } start_src_e;
endpackage

// File: rtl/sar_trig_sel.sv
`timescale 1ns/1ps
module sar_trig_sel
  import sar_conv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       sw_start,
  input  logic       tmr2_ovf,
  input  logic       tmr3_ovf,
  input  logic       ext_pin,
  output logic       start_req
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] pin_chain;
  logic             pin_rise;
  start_src_e       sel;

  always_ff @(posedge clk) begin
    if (!rst_n) pin_chain <= '0;
    else        pin_chain <= {pin_chain[CHAIN-2:0], ext_pin};
  end

  assign pin_rise = pin_chain[CHAIN-2] & ~pin_chain[CHAIN-1];
  assign sel      = start_src_e'(mode);

  always_comb begin
    unique case (sel)
      SRC_SOFT: start_req = sw_start;
      SRC_TMR2: start_req = tmr2_ovf;
      SRC_TMR3: start_req = tmr3_ovf;
      SRC_PIN:  start_req = pin_rise;
      default:  start_req = 1'b0;
    endcase
  end

  // R1: a pin edge is reported for one cycle only
  a_r1_pin_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    pin_rise |=> !pin_rise);
endmodule

// File: rtl/sar_step_timer.sv
`timescale 1ns/1ps
module sar_step_timer #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_n,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      div_q <= '0;
    end else if (restart) begin
      cnt   <= '0;
      div_q <= div_n;
    end else if (!run || tick) begin
      cnt   <= '0;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == div_q);

  // R3: with a divider above zero, ticks never come back to back
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_q != '0 && !restart) |=> !tick);
endmodule

// File: rtl/sar_core.sv
`timescale 1ns/1ps
module sar_core #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start_req,
  input  logic             tick,
  input  logic             cmp_in,
  output logic             start_ok,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] code
);
  localparam int IDX_W = $clog2(RES_W);
  localparam logic [RES_W-1:0] FIRST_TRIAL = {1'b1, {(RES_W-1){1'b0}}};
  localparam logic [IDX_W-1:0] TOP_IDX     = IDX_W'(RES_W-1);

  logic [IDX_W-1:0] idx;

  assign start_ok = start_req && enable && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      code <= '0;
      idx  <= '0;
    end else begin
      done <= 1'b0;
      if (busy && !enable) begin
        busy <= 1'b0;
      end else if (start_ok) begin
        busy <= 1'b1;
        code <= FIRST_TRIAL;
        idx  <= TOP_IDX;
      end else if (busy && tick) begin
        code[idx] <= cmp_in;
        if (idx == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          code[idx-1'b1] <= 1'b1;
          idx            <= idx - 1'b1;
        end
      end
    end
  end

  // R3: an accepted trigger raises busy
  a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> busy);
  // R5: each conversion opens on the mid-scale trial
  a_r5_first_trial: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> code == FIRST_TRIAL);
  // R5: the trial code moves only on a step
  a_r5_code_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && enable && !tick) |=> $stable(code));
  // R2: dropping enable ends the conversion without completion
  a_r2_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !enable) |=> (!busy && !done));
endmodule

// File: rtl/sar_word_fmt.sv
`timescale 1ns/1ps
module sar_word_fmt #(
  parameter int RES_W = 12,
  parameter int OUT_W = 16
) (
  input  logic [RES_W-1:0] raw,
  input  logic             diff_mode,
  input  logic             justify,
  output logic [OUT_W-1:0] word
);
  localparam int PAD = OUT_W - RES_W;

  logic [RES_W-1:0] coded;
  logic             fill;

  assign coded = diff_mode ? {~raw[RES_W-1], raw[RES_W-2:0]} : raw;
  assign fill  = diff_mode & coded[RES_W-1];

  always_comb begin
    if (justify) word = {coded, {PAD{1'b0}}};
    else         word = {{PAD{fill}}, coded};
  end

  initial begin
    assert (OUT_W > RES_W) else $error("result word must be wider than the code");
  end
endmodule

// File: rtl/sar_conv_seq.sv
`timescale 1ns/1ps
module sar_conv_seq #(
  parameter int RES_W = 12,
  parameter int OUT_W = 16,
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       trig_mode,
  input  logic             sw_start,
  input  logic             tmr2_ovf,
  input  logic             tmr3_ovf,
  input  logic             ext_start,
  input  logic [DIV_W-1:0] div_n,
  input  logic             diff_mode,
  input  logic             justify,
  input  logic             irq_en,
  input  logic             flag_clr,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic             busy,
  output logic             eoc_flag,
  output logic             irq,
  output logic [OUT_W-1:0] result
);
  logic             start_req;
  logic             start_ok;
  logic             tick;
  logic             done;
  logic [OUT_W-1:0] word;

  sar_trig_sel #(.SYNC_STAGES(2)) u_trig (
    .clk(clk), .rst_n(rst_n), .mode(trig_mode), .sw_start(sw_start),
    .tmr2_ovf(tmr2_ovf), .tmr3_ovf(tmr3_ovf), .ext_pin(ext_start),
    .start_req(start_req)
  );

  sar_step_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(start_ok),
    .div_n(div_n), .tick(tick)
  );

  sar_core #(.RES_W(RES_W)) u_core (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start_req(start_req),
    .tick(tick), .cmp_in(cmp_in), .start_ok(start_ok), .busy(busy),
    .done(done), .code(dac_code)
  );

  sar_word_fmt #(.RES_W(RES_W), .OUT_W(OUT_W)) u_fmt (
    .raw(dac_code), .diff_mode(diff_mode), .justify(justify), .word(word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result   <= '0;
      eoc_flag <= 1'b0;
    end else begin
      if (done) result <= word;
      if (done)          eoc_flag <= 1'b1;
      else if (flag_clr) eoc_flag <= 1'b0;
    end
  end

  assign irq = eoc_flag & irq_en;

  // R4: completion raises the flag on the next edge
  a_r4_flag_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> eoc_flag);
  // R4: the flag drops only through a clear
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_flag && !flag_clr) |=> eoc_flag);
  // R9: the result word holds between completions
  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(result));
  // R6: a left-justified word has a zero low nibble
  a_r6_left_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && justify) |=> result[OUT_W-RES_W-1:0] == '0);
  // R2: no trigger is accepted while disabled
  a_r2_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !enable) |=> !busy);
endmodule

// File: tb/sar_conv_seq_test.sv
`timescale 1ns/1ps
module sar_conv_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable, sw_start, tmr2_ovf, tmr3_ovf, ext_start;
  logic [1:0]  trig_mode;
  logic [4:0]  div_n;
  logic        diff_mode, justify, irq_en, flag_clr, cmp_in;
  logic [11:0] dac_code;
  logic        busy, eoc_flag, irq;
  logic [15:0] result;
  int          lvl;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  sar_conv_seq uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .trig_mode(trig_mode),
    .sw_start(sw_start), .tmr2_ovf(tmr2_ovf), .tmr3_ovf(tmr3_ovf),
    .ext_start(ext_start), .div_n(div_n), .diff_mode(diff_mode),
    .justify(justify), .irq_en(irq_en), .flag_clr(flag_clr), .cmp_in(cmp_in),
    .dac_code(dac_code), .busy(busy), .eoc_flag(eoc_flag), .irq(irq),
    .result(result)
  );

  // comparator model: level in code units, differential shifted by mid-scale
  always_comb cmp_in = ((diff_mode ? lvl + 2048 : lvl) >= int'(dac_code));

  function automatic logic [15:0] exp_word(int v, bit d, bit j);
    int s = d ? v + 2048 : v;
    logic [11:0] c;
    if (s < 0) s = 0;
    if (s > 4095) s = 4095;
    c = s[11:0];
    if (d) c[11] = ~c[11];
    if (j) return {c, 4'b0};
    return {{4{d & c[11]}}, c};
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pulse(int s);
    @(negedge clk);
    case (s)
      0: sw_start = 1'b1;
      1: tmr2_ovf = 1'b1;
      2: tmr3_ovf = 1'b1;
      default: ext_start = 1'b1;
    endcase
    @(negedge clk);
    sw_start = 1'b0; tmr2_ovf = 1'b0; tmr3_ovf = 1'b0; ext_start = 1'b0;
  endtask

  task automatic wait_busy(output bit seen);
    seen = 0;
    for (int i = 0; i < 8 && !seen; i++) begin
      if (busy) seen = 1; else @(negedge clk);
    end
  endtask

  task automatic count_busy(output int cycles);
    cycles = 0;
    while (busy && cycles < 2000) begin
      cycles++;
      @(negedge clk);
    end
  endtask

  // full conversion with the given setup; checks length, word and flag
  task automatic convert(int mode, int dv, int v, bit d, bit j, string tag);
    bit seen;
    int cyc;
    trig_mode = 2'(mode); div_n = 5'(dv); lvl = v; diff_mode = d; justify = j;
    pulse(mode);
    wait_busy(seen);
    check({tag, " R1 start"}, 32'(seen), 32'd1);
    count_busy(cyc);
    check({tag, " R3 length"}, cyc, 12 * (dv + 1));
    @(negedge clk);
    check({tag, " R5/R6/R7 word"}, 32'(result), 32'(exp_word(v, d, j)));
    check({tag, " R4 flag"}, 32'(eoc_flag), 32'd1);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit seen;
    int cyc;
    logic [15:0] held;
    void'($urandom(32'd4242));
    rst_n = 0; enable = 0; trig_mode = 0; sw_start = 0; tmr2_ovf = 0;
    tmr3_ovf = 0; ext_start = 0; div_n = 0; diff_mode = 0; justify = 0;
    irq_en = 0; flag_clr = 0; lvl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("reset busy", 32'(busy), 0);
    check("reset flag R4", 32'(eoc_flag), 0);
    check("reset result R9", 32'(result), 0);

    // R2: trigger while disabled
    pulse(0); repeat (3) @(negedge clk);
    check("R2 disabled trigger ignored", 32'(busy), 0);
    enable = 1;

    // directed corners: R5 unipolar, R6 justify, R7 differential
    convert(0, 0, 4095, 0, 0, "R5 full scale");
    convert(0, 1, 9000, 0, 0, "R5 overrange");
    convert(1, 2, 2048, 0, 0, "R5 half scale");
    convert(2, 0, 2048, 0, 1, "R6 left half");
    convert(3, 0, 0, 1, 0, "R7 zero");
    convert(0, 0, 5000, 1, 0, "R7 pos sat");
    convert(0, 0, -5000, 1, 0, "R7 neg sat");
    convert(0, 0, -1024, 1, 1, "R7 left neg");
    convert(0, 16, 1234, 0, 0, "R3 div17");

    // R4: irq gating and clear
    convert(0, 0, 77, 0, 0, "R4 setup");
    pulse(0);
    wait_busy(seen); count_busy(cyc); @(negedge clk);
    irq_en = 0; @(negedge clk);
    check("R4 irq masked", 32'(irq), 0);
    irq_en = 1; @(negedge clk);
    check("R4 irq raised", 32'(irq), 1);
    flag_clr = 1; @(negedge clk); flag_clr = 0;
    check("R4 flag cleared", 32'(eoc_flag), 0);
    check("R4 irq dropped", 32'(irq), 0);
    irq_en = 0;

    // R8: retrigger during conversion ignored
    trig_mode = 0; div_n = 3; lvl = 3000; diff_mode = 0; justify = 0;
    pulse(0); wait_busy(seen);
    repeat (10) @(negedge clk);
    pulse(0);
    count_busy(cyc);
    check("R8 length with retrigger", cyc, 48 - 12);
    @(negedge clk);
    check("R8 word with retrigger", 32'(result), 32'(exp_word(3000, 0, 0)));
    @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0;

    // R2: abort mid-conversion; R9: result held
    held = result;
    div_n = 2; lvl = 100;
    pulse(0); wait_busy(seen);
    repeat (7) @(negedge clk);
    enable = 0; @(negedge clk);
    check("R2 abort clears busy", 32'(busy), 0);
    repeat (3) @(negedge clk);
    check("R2 abort no flag", 32'(eoc_flag), 0);
    check("R9 result held after abort", 32'(result), 32'(held));
    enable = 1;

    // R1: unselected sources ignored, then random conversions
    for (int it = 0; it < 40; it++) begin
      int m = $urandom % 4;
      int other = (m + 1 + ($urandom % 3)) % 4;
      int dv = ($urandom % 8 == 0) ? 31 : $urandom % 4;
      bit d = $urandom % 2;
      bit j = $urandom % 2;
      int v = d ? int'($urandom % 4600) - 2300 : int'($urandom % 4600) - 200;
      trig_mode = 2'(m);
      pulse(other); repeat (4) @(negedge clk);
      check("R1 unselected source ignored", 32'(busy), 0);
      held = result;
      check("R9 result steady", 32'(result), 32'(held));
      convert(m, dv, v, d, j, "rand");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule